// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block watches the two wires of an I2C bus from inside a synchronous design. The raw SDA and SCL levels pass through a chain of synchronising flops. Edges seen on the synchronised SDA while SCL is high are classed as bus conditions. A falling SDA edge opens a transfer, and a rising one closes it. The block reports each condition as a single-clock pulse. It also holds a level that shows whether a transfer is in progress.

A bus master that wants to open a transfer raises `start_req`. The block then takes the SDA wire low through `sda_pull`, but only if the line is still high when the request arrives. If another device already holds SDA low, the request is dropped and a sticky collision flag is raised. A dedicated clear input resets that flag. An interrupt request combines the condition pulses with two enables. A build parameter selects a mode in which every condition interrupts and the enables are ignored.

Top module: `i2c_cond_detect`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `start_pulse`, `restart_pulse`, `stop_pulse`, `bus_active`, `bus_coll`, `sda_pull` and `irq` are all 0.
- R2: A falling SDA edge while SCL is high, with the bus idle, produces exactly one `start_pulse` of one clock. The pulse is visible after SYNC_STAGES+1 rising clock edges, counted from the first edge that samples the new SDA level. At most one of the three condition pulses is high in any cycle.
- R3: `bus_active` rises in the same cycle as `start_pulse` and falls in the same cycle as `stop_pulse`.
- R4: A rising SDA edge while SCL is high produces one `stop_pulse`, provided the bus is active and SCL has been low at least once since the last start or repeated start.
- R5: If SCL has stayed high since the last start or repeated start, a rising SDA edge gives no pulse. A following falling SDA edge gives no pulse either. `bus_active` stays 1.
- R6: A falling SDA edge while SCL is high gives one `restart_pulse` and no `start_pulse`. This needs an active bus and at least one SCL low phase since the last start. `bus_active` stays 1, and a Stop again needs a new SCL low phase.
- R7: SDA edges while SCL is low produce no condition pulse.
- R8: If synchronised SDA is low in the cycle where `start_req` rises, `bus_coll` is set and `sda_pull` stays 0 for as long as that request is held.
- R9: If synchronised SDA is high in the cycle where `start_req` rises, `sda_pull` is 1 from the next cycle. It stays 1 until the cycle after `start_req` falls.
- R10: `bus_coll` stays set until a cycle with `coll_clr` high. A new collision in the same cycle as `coll_clr` leaves the flag set.
- R11: `irq` is high in the cycle of a `start_pulse` or `restart_pulse` when `en_start` is 1, and in the cycle of a `stop_pulse` when `en_stop` is 1. It is low in every other cycle. With IRQ_ALWAYS=1, `irq` follows every condition pulse whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sda_in | input | 1 | Raw SDA wire level |
| scl_in | input | 1 | Raw SCL wire level |
| start_req | input | 1 | Master request to open a transfer, held as a level |
| coll_clr | input | 1 | Clears the collision flag |
| en_start | input | 1 | Lets start and repeated start raise `irq` |
| en_stop | input | 1 | Lets stop raise `irq` |
| start_pulse | output | 1 | One-clock Start indication |
| restart_pulse | output | 1 | One-clock Repeated Start indication |
| stop_pulse | output | 1 | One-clock Stop indication |
| bus_active | output | 1 | A transfer is in progress |
| bus_coll | output | 1 | Sticky collision flag |
| sda_pull | output | 1 | Drive SDA low for a granted start |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two copies of the block on the same bus wires. The first copy uses SYNC_STAGES=2 and IRQ_ALWAYS=0. On this copy the exact pulse latency is measured, and the masking of `irq` by each enable is checked. The second copy uses SYNC_STAGES=3 and IRQ_ALWAYS=1. It shows that condition classification does not depend on synchroniser depth, and that the enables have no effect in the always-interrupt mode.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  typedef struct packed {
    logic start;
    logic restart;
    logic stop;
  } cond_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_track.sv
module i2c_cond_track
  import i2c_cond_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sda_s,
  input  logic      scl_s,
  output cond_evt_t evt,
  output logic      active
);
  logic sda_d;
  logic low_seen;
  logic sda_fall, sda_rise;

  always_comb begin
    sda_fall = sda_d & ~sda_s;
    sda_rise = ~sda_d & sda_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_d    <= 1'b1;
      active   <= 1'b0;
      low_seen <= 1'b0;
      evt      <= '0;
    end else begin
      sda_d <= sda_s;
      evt   <= '0;
      if (!scl_s) low_seen <= 1'b1;
      if (scl_s && sda_fall) begin
        if (!active) begin
          evt.start <= 1'b1;
          active    <= 1'b1;
          low_seen  <= 1'b0;
        end else if (low_seen) begin
          evt.restart <= 1'b1;
          low_seen    <= 1'b0;
        end
      end else if (scl_s && sda_rise && active && low_seen) begin
        evt.stop <= 1'b1;
        active   <= 1'b0;
        low_seen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_start_guard.sv
module i2c_start_guard (
  input  logic clk,
  input  logic rst,
  input  logic sda_s,
  input  logic start_req,
  input  logic coll_clr,
  output logic sda_pull,
  output logic coll
);
  logic req_d;
  logic req_rise;

  assign req_rise = start_req & ~req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d    <= 1'b0;
      sda_pull <= 1'b0;
      coll     <= 1'b0;
    end else begin
      req_d <= start_req;
      if (req_rise) sda_pull <= sda_s;
      else if (!start_req) sda_pull <= 1'b0;
      if (req_rise && !sda_s) coll <= 1'b1;
      else if (coll_clr) coll <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit IRQ_ALWAYS  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_in,
  input  logic scl_in,
  input  logic start_req,
  input  logic coll_clr,
  input  logic en_start,
  input  logic en_stop,
  output logic start_pulse,
  output logic restart_pulse,
  output logic stop_pulse,
  output logic bus_active,
  output logic bus_coll,
  output logic sda_pull,
  output logic irq
);
  logic      sda_s, scl_s;
  cond_evt_t evt;
  logic      start_ok, stop_ok;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_s));

  i2c_cond_track u_track (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_s(scl_s),
    .evt(evt), .active(bus_active));

  i2c_start_guard u_guard (
    .clk(clk), .rst(rst), .sda_s(sda_s), .start_req(start_req),
    .coll_clr(coll_clr), .sda_pull(sda_pull), .coll(bus_coll));

  generate
    if (IRQ_ALWAYS) begin : g_irq_all
      assign start_ok = 1'b1;
      assign stop_ok  = 1'b1;
    end else begin : g_irq_en
      assign start_ok = en_start;
      assign stop_ok  = en_stop;
    end
  endgenerate

  assign start_pulse   = evt.start;
  assign restart_pulse = evt.restart;
  assign stop_pulse    = evt.stop;
  assign irq = ((evt.start | evt.restart) & start_ok) | (evt.stop & stop_ok);
endmodule

// File: rtl/i2c_cond_detect_chk.sv
module i2c_cond_detect_chk #(
  parameter bit IRQ_ALWAYS = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic start_req,
  input logic coll_clr,
  input logic en_stop,
  input logic start_pulse,
  input logic restart_pulse,
  input logic stop_pulse,
  input logic bus_active,
  input logic bus_coll,
  input logic sda_pull,
  input logic irq
);
  AST_ONE_CONDITION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_pulse, restart_pulse, stop_pulse})); // R2
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse); // R2
  AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> bus_active && !$past(bus_active)); // R3
  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> !bus_active && $past(bus_active)); // R3
  AST_RESTART_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |-> bus_active && $past(bus_active)); // R6
  AST_COLL_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_coll) |-> !sda_pull); // R8
  AST_PULL_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> $past(start_req)); // R9
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (rst)
    bus_coll && !coll_clr |=> bus_coll); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (start_pulse || restart_pulse || stop_pulse)); // R11
  AST_IRQ_STOP_MASK: assert property (@(posedge clk) disable iff (rst)
    (!IRQ_ALWAYS && !en_stop && stop_pulse) |-> !irq); // R11
endmodule

bind i2c_cond_detect i2c_cond_detect_chk #(.IRQ_ALWAYS(IRQ_ALWAYS)) u_chk (
  .clk(clk), .rst(rst), .start_req(start_req), .coll_clr(coll_clr),
  .en_stop(en_stop), .start_pulse(start_pulse), .restart_pulse(restart_pulse),
  .stop_pulse(stop_pulse), .bus_active(bus_active), .bus_coll(bus_coll),
  .sda_pull(sda_pull), .irq(irq));

// File: tb/i2c_cond_detect_bench.sv
module i2c_cond_detect_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sda = 1'b1, scl = 1'b1;
  logic start_req = 1'b0, coll_clr = 1'b0, en_start = 1'b0, en_stop = 1'b0;
  logic start_pulse, restart_pulse, stop_pulse, bus_active, bus_coll, sda_pull, irq;
  logic a_start, a_restart, a_stop, a_active, a_coll, a_pull, a_irq;
  int checks = 0, errors = 0;
  int n_start = 0, n_restart = 0, n_stop = 0, n_irq = 0, n_irq_a = 0;
  int n_start_a = 0, n_stop_a = 0;

  always #10 clk = ~clk;

  i2c_cond_detect #(.SYNC_STAGES(2), .IRQ_ALWAYS(1'b0)) u_i2c_cond_detect (
    .clk(clk), .rst(rst), .sda_in(sda), .scl_in(scl), .start_req(start_req),
    .coll_clr(coll_clr), .en_start(en_start), .en_stop(en_stop),
    .start_pulse(start_pulse), .restart_pulse(restart_pulse), .stop_pulse(stop_pulse),
    .bus_active(bus_active), .bus_coll(bus_coll), .sda_pull(sda_pull), .irq(irq));

  i2c_cond_detect #(.SYNC_STAGES(3), .IRQ_ALWAYS(1'b1)) u_i2c_cond_detect_always (
    .clk(clk), .rst(rst), .sda_in(sda), .scl_in(scl), .start_req(start_req),
    .coll_clr(coll_clr), .en_start(en_start), .en_stop(en_stop),
    .start_pulse(a_start), .restart_pulse(a_restart), .stop_pulse(a_stop),
    .bus_active(a_active), .bus_coll(a_coll), .sda_pull(a_pull), .irq(a_irq));

  always @(negedge clk) begin
    if (start_pulse) n_start++;
    if (restart_pulse) n_restart++;
    if (stop_pulse) n_stop++;
    if (irq) n_irq++;
    if (a_irq) n_irq_a++;
    if (a_start) n_start_a++;
    if (a_stop) n_stop_a++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_start = 0; n_restart = 0; n_stop = 0; n_irq = 0; n_irq_a = 0;
    n_start_a = 0; n_stop_a = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_stop();
    scl = 1'b0; run(4);
    sda = 1'b0; run(4);
    scl = 1'b1; run(4);
    sda = 1'b1; run(6);
  endtask

  task automatic t_reset();
    rst = 1'b1; run(3);
    chk("R1 start_pulse", start_pulse, 0);
    chk("R1 bus_active", bus_active, 0);
    chk("R1 bus_coll", bus_coll, 0);
    chk("R1 sda_pull/irq", {sda_pull, irq, restart_pulse, stop_pulse}, 0);
    rst = 1'b0; run(4);
    chk("R1 idle after release", {start_pulse, bus_active, irq}, 0);
  endtask

  task automatic t_start_latency();
    @(negedge clk); sda = 1'b0;
    run(2);
    chk("R2 no pulse before latency", start_pulse, 0);
    run(1);
    chk("R2 pulse at SYNC_STAGES+1 edges", start_pulse, 1);
    chk("R3 active with start", bus_active, 1);
    run(1);
    chk("R2 pulse one clock", start_pulse, 0);
    bus_stop();
  endtask

  task automatic t_start_stop();
    clr_counts();
    sda = 1'b0; run(6);
    chk("R3 active after start", bus_active, 1);
    bus_stop();
    chk("R4 stop count", n_stop, 1);
    chk("R3 idle after stop", bus_active, 0);
    chk("R2 start count, deep sync", n_start_a, 1);
    chk("R4 stop count, deep sync", n_stop_a, 1);
  endtask

  task automatic t_no_low_glitch();
    clr_counts();
    sda = 1'b0; run(6);
    sda = 1'b1; run(6);
    chk("R5 no stop without SCL low", n_stop, 0);
    chk("R5 bus stays active", bus_active, 1);
    sda = 1'b0; run(6);
    chk("R5 no second condition", n_start + n_restart, 1);
    bus_stop();
    chk("R5 cleanup stop", n_stop, 1);
  endtask

  task automatic t_restart();
    clr_counts();
    sda = 1'b0; run(6);
    scl = 1'b0; run(4);
    sda = 1'b1; run(4);
    scl = 1'b1; run(4);
    sda = 1'b0; run(6);
    chk("R6 restart count", n_restart, 1);
    chk("R6 no extra start", n_start, 1);
    chk("R6 bus still active", bus_active, 1);
    sda = 1'b1; run(6);
    chk("R6 stop needs new low phase", n_stop, 0);
    bus_stop();
    chk("R6 stop after low phase", n_stop, 1);
  endtask

  task automatic t_scl_low_edges();
    sda = 1'b0; run(6);
    scl = 1'b0; run(4);
    clr_counts();
    for (int i = 0; i < 4; i++) begin
      sda = ~sda; run(4);
    end
    chk("R7 no pulses with SCL low", n_start + n_restart + n_stop, 0);
    bus_stop();
  endtask

  task automatic t_collision();
    start_req = 1'b1; run(1);
    chk("R9 pull granted", sda_pull, 1);
    chk("R9 no collision", bus_coll, 0);
    run(3);
    chk("R9 pull held", sda_pull, 1);
    start_req = 1'b0; run(1);
    chk("R9 pull released", sda_pull, 0);
    sda = 1'b0; run(6);
    start_req = 1'b1; run(1);
    chk("R8 collision set", bus_coll, 1);
    chk("R8 no pull", sda_pull, 0);
    run(3);
    chk("R8 pull stays off", sda_pull, 0);
    start_req = 1'b0; run(3);
    chk("R10 flag sticky", bus_coll, 1);
    coll_clr = 1'b1; run(1); coll_clr = 1'b0;
    chk("R10 flag cleared", bus_coll, 0);
    start_req = 1'b1; coll_clr = 1'b1; run(1);
    coll_clr = 1'b0; start_req = 1'b0;
    chk("R10 set wins over clear", bus_coll, 1);
    coll_clr = 1'b1; run(1); coll_clr = 1'b0;
    bus_stop();
  endtask

  task automatic t_irq();
    en_start = 1'b0; en_stop = 1'b0; clr_counts();
    sda = 1'b0; run(6); bus_stop();
    chk("R11 masked irq", n_irq, 0);
    chk("R11 always mode ignores enables", n_irq_a, 2);
    en_start = 1'b1; clr_counts();
    sda = 1'b0; run(6); bus_stop();
    chk("R11 start enable only", n_irq, 1);
    en_start = 1'b0; en_stop = 1'b1; clr_counts();
    sda = 1'b0; run(6); bus_stop();
    chk("R11 stop enable only", n_irq, 1);
    en_start = 1'b1; clr_counts();
    sda = 1'b0; run(6);
    scl = 1'b0; run(4); sda = 1'b1; run(4); scl = 1'b1; run(4);
    sda = 1'b0; run(6); bus_stop();
    chk("R11 start restart stop", n_irq, 3);
    en_start = 1'b0; en_stop = 1'b0;
  endtask

  initial begin
    run(2000);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_start_latency();
    t_start_stop();
    t_no_low_glitch();
    t_restart();
    t_scl_low_edges();
    t_collision();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule